// File: doc/BRIEF.md
# Triggered Latency Pipeline Controller

This block records a binary hit vector for every channel on every clock in a circular pipeline of fixed depth. A trigger pointer follows the write pointer at a programmable separation, the latency. When a trigger arrives, the pipeline word under the trigger pointer is copied into a small event buffer together with its pipeline address. The trigger pointer addresses the word that was stored `latency_i` clocks before the trigger.

After reset the write pointer starts on its own. The trigger pointer is held until the write pointer reaches the programmed latency, and from then on both pointers advance together. A check runs on every clock once the trigger pointer is running. If the pointer separation ever differs from `latency_i`, it raises a sticky error, and every event captured from that clock on carries the error. A trigger that finds the buffer full is dropped and raises a sticky full error.

Events leave through a valid/ready port. `ev_valid_o` is high while the buffer holds an event, and the oldest event is shown on the payload outputs. The event is removed on a clock where both `ev_valid_o` and `ev_ready_i` are high. While `ev_ready_i` is low, the event stays on the port unchanged. Pipeline and buffer depths must be powers of two.

Top module: `lpc_trig_pipeline`

## Requirements
- R1: After reset the pipeline write address is 0 on the first clock. It advances by one on every clock and wraps from 255 to 0. The hit vector present on each clock is stored at that clock's write address.
- R2: Call the first clock after reset clock 0. A trigger accepted on clock c produces an event with the hit vector stored on clock c−L and the address (c−L) mod 256, where L is `latency_i` (L ≥ 1). With L = 0, the event holds the word stored 256 clocks earlier at address c mod 256.
- R3: Triggers on clocks 0 to L−1 after reset, before the trigger pointer has started, are ignored and produce no event.
- R4: Once the trigger pointer runs, a clock on which the pointer separation differs from `latency_i` sets `lat_err_o` from the next clock onward. `lat_err_o` stays set until reset or a clock with `clr_i` high and no mismatch. It never sets while `latency_i` stays at the value it had at reset.
- R5: `ev_lat_err_o` of an event is 1 if `lat_err_o` was already set, or a mismatch was detected, on its capture clock. Otherwise it is 0.
- R6: After reset the buffer is empty and `ev_valid_o`, `lat_err_o` and `full_err_o` are low. `ev_valid_o` is high exactly while at least one event is stored, and events leave in capture order.
- R7: An event is removed on a clock with `ev_valid_o` and `ev_ready_i` both high. While `ev_ready_i` is low, `ev_valid_o` stays high and the payload stays stable.
- R8: The buffer holds 32 events. A trigger arriving while it holds 32 is dropped, even if an event is popped on that clock. The drop sets `full_err_o` from the next clock. The flag stays set until `clr_i` is high on a clock without a drop; a drop on the same clock as `clr_i` keeps it set.
- R9: A trigger and a pop on the same clock both take effect, so the occupancy is unchanged and the next event moves to the head.
- R10: With `ev_ready_i` held high, triggers every third clock are all captured and read out, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latency_i | input | 8 | Programmed separation between write and trigger pointers |
| hit_i | input | 128 | Binary hit vector, one bit per channel, stored every clock |
| trig_i | input | 1 | Trigger request |
| clr_i | input | 1 | Clears the sticky error flags |
| ev_valid_o | output | 1 | An event is offered |
| ev_ready_i | input | 1 | Readout accepts the offered event |
| ev_hits_o | output | 128 | Hit vector of the offered event |
| ev_addr_o | output | 8 | Pipeline address of the offered event |
| ev_lat_err_o | output | 1 | Latency error tag of the offered event |
| lat_err_o | output | 1 | Sticky latency error |
| full_err_o | output | 1 | Sticky dropped-trigger error |

## Verification
The assertions cover the properties that hold on every clock:
- the write address steps by one;
- occupancy never exceeds the buffer depth;
- a trigger plus a pop leaves occupancy unchanged;
- the error flags stay sticky, and a full-buffer trigger raises the full error;
- an offered event is held stable under back-pressure.

Which pipeline word a trigger captures, across latencies including 0, 255 and address wrap, can only be shown by the bench's scenarios. The same holds for ignoring early triggers, capture order, the error tag on events, and lossless readout at the highest trigger rate.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  // Trigger pointer phase: waiting for the latency to build up, then running
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/lpc_ptr_ctrl.sv
module lpc_ptr_ctrl
  import lpc_pkg::*;
#(
  parameter int PIPE_DEPTH = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(PIPE_DEPTH)-1:0] latency_i,
  input  logic                          clr_i,
  output logic [$clog2(PIPE_DEPTH)-1:0] wr_addr_o,
  output logic [$clog2(PIPE_DEPTH)-1:0] rd_addr_o,
  output logic                          live_o,
  output logic                          mismatch_o,
  output logic                          lat_err_o
);
  localparam int AW = $clog2(PIPE_DEPTH);

  phase_e        phase_q;
  logic [AW-1:0] wr_q, rd_q, sep;
  logic          at_start, err_q;

  // The trigger pointer starts on the clock the write pointer equals the latency
  assign at_start   = (phase_q == PH_FILL) && (wr_q == latency_i);
  assign live_o     = (phase_q == PH_RUN) || at_start;
  assign sep        = wr_q - rd_q;                 // modulo pipeline depth
  assign mismatch_o = live_o && (sep != latency_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      phase_q <= PH_FILL;
      err_q   <= 1'b0;
    end else begin
      wr_q <= wr_q + AW'(1);
      if (live_o)   rd_q    <= rd_q + AW'(1);
      if (at_start) phase_q <= PH_RUN;
      if (mismatch_o)  err_q <= 1'b1;
      else if (clr_i)  err_q <= 1'b0;
    end
  end

  assign wr_addr_o = wr_q;
  assign rd_addr_o = rd_q;
  assign lat_err_o = err_q;
endmodule

// File: rtl/lpc_pipe_mem.sv
module lpc_pipe_mem #(
  parameter int WIDTH      = 128,
  parameter int PIPE_DEPTH = 256
) (
  input  logic                          clk,
  input  logic [$clog2(PIPE_DEPTH)-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]              wr_data_i,
  input  logic [$clog2(PIPE_DEPTH)-1:0] rd_addr_i,
  output logic [WIDTH-1:0]              rd_data_o
);
  logic [WIDTH-1:0] ram [PIPE_DEPTH];

  // Written on every clock; the read returns the content before this clock's write
  always_ff @(posedge clk) ram[wr_addr_i] <= wr_data_i;

  assign rd_data_o = ram[rd_addr_i];
endmodule

// File: rtl/lpc_event_fifo.sv
module lpc_event_fifo #(
  parameter int WIDTH = 137,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [WIDTH-1:0]             data_i,
  input  logic                         pop_i,
  output logic                         valid_o,
  output logic [WIDTH-1:0]             data_o,
  output logic [$clog2(DEPTH+1)-1:0]   occ_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    occ_q;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && (occ_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (occ_q != '0);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) if (push_ok) store[wp_q] <= data_i;

  // Up/down occupancy counter decides whether data is waiting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_ok) wp_q <= step(wp_q);
      if (pop_ok)  rp_q <= step(rp_q);
      if (push_ok && !pop_ok)      occ_q <= occ_q + CW'(1);
      else if (pop_ok && !push_ok) occ_q <= occ_q - CW'(1);
    end
  end

  assign valid_o = (occ_q != '0);
  assign data_o  = store[rp_q];
  assign occ_o   = occ_q;
endmodule

// File: rtl/lpc_trig_pipeline.sv
module lpc_trig_pipeline
  import lpc_pkg::*;
#(
  parameter int NCH        = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int BUF_DEPTH  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(PIPE_DEPTH)-1:0] latency_i,
  input  logic [NCH-1:0]                hit_i,
  input  logic                          trig_i,
  input  logic                          clr_i,
  output logic                          ev_valid_o,
  input  logic                          ev_ready_i,
  output logic [NCH-1:0]                ev_hits_o,
  output logic [$clog2(PIPE_DEPTH)-1:0] ev_addr_o,
  output logic                          ev_lat_err_o,
  output logic                          lat_err_o,
  output logic                          full_err_o
);
  localparam int AW = $clog2(PIPE_DEPTH);
  localparam int CW = $clog2(BUF_DEPTH+1);
  localparam int EW = 1 + AW + NCH;

  logic [AW-1:0]  wr_addr, rd_addr;
  logic           live, mismatch;
  logic [NCH-1:0] slot;
  logic [EW-1:0]  ev_in, ev_out;
  logic [CW-1:0]  occ;
  logic           push, pop, drop, full_q, tag;

  lpc_ptr_ctrl #(.PIPE_DEPTH(PIPE_DEPTH)) i_ptr (
    .clk(clk), .rst_n(rst_n), .latency_i(latency_i), .clr_i(clr_i),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr), .live_o(live),
    .mismatch_o(mismatch), .lat_err_o(lat_err_o)
  );

  lpc_pipe_mem #(.WIDTH(NCH), .PIPE_DEPTH(PIPE_DEPTH)) i_pipe (
    .clk(clk), .wr_addr_i(wr_addr), .wr_data_i(hit_i),
    .rd_addr_i(rd_addr), .rd_data_o(slot)
  );

  // An event inherits an error already flagged or detected on its capture clock
  assign tag   = lat_err_o | mismatch;
  assign ev_in = {tag, rd_addr, slot};
  assign drop  = trig_i && live && (occ == CW'(BUF_DEPTH));
  assign push  = trig_i && live && !drop;
  assign pop   = ev_valid_o && ev_ready_i;

  lpc_event_fifo #(.WIDTH(EW), .DEPTH(BUF_DEPTH)) i_buf (
    .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(ev_in),
    .pop_i(pop), .valid_o(ev_valid_o), .data_o(ev_out), .occ_o(occ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full_q <= 1'b0;
    else if (drop)   full_q <= 1'b1;
    else if (clr_i)  full_q <= 1'b0;
  end

  assign full_err_o   = full_q;
  assign ev_lat_err_o = ev_out[EW-1];
  assign ev_addr_o    = ev_out[NCH +: AW];
  assign ev_hits_o    = ev_out[NCH-1:0];
endmodule

// File: rtl/lpc_trig_pipeline_chk.sv
module lpc_trig_pipeline_chk #(
  parameter int NCH        = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int BUF_DEPTH  = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          trig_i,
  input logic                          clr_i,
  input logic                          ev_valid_o,
  input logic                          ev_ready_i,
  input logic [NCH-1:0]                ev_hits_o,
  input logic [$clog2(PIPE_DEPTH)-1:0] ev_addr_o,
  input logic                          lat_err_o,
  input logic                          full_err_o,
  input logic [$clog2(PIPE_DEPTH)-1:0] wr_addr,
  input logic [$clog2(BUF_DEPTH+1)-1:0] occ,
  input logic                          push,
  input logic                          pop
);
  localparam int CW = $clog2(BUF_DEPTH+1);

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_addr == $past(wr_addr) + 1'b1); // R1

  AST_LAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lat_err_o && !clr_i |=> lat_err_o); // R4

  AST_HOLD_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o && !ev_ready_i |=> ev_valid_o && $stable(ev_addr_o) && $stable(ev_hits_o)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(BUF_DEPTH)); // R8

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && occ == CW'(BUF_DEPTH) |=> full_err_o); // R8

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full_err_o && !clr_i |=> full_err_o); // R8

  AST_PUSH_POP_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> occ == $past(occ)); // R9
endmodule

bind lpc_trig_pipeline lpc_trig_pipeline_chk #(
  .NCH(NCH), .PIPE_DEPTH(PIPE_DEPTH), .BUF_DEPTH(BUF_DEPTH)
) i_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .clr_i(clr_i),
  .ev_valid_o(ev_valid_o), .ev_ready_i(ev_ready_i), .ev_hits_o(ev_hits_o),
  .ev_addr_o(ev_addr_o), .lat_err_o(lat_err_o), .full_err_o(full_err_o),
  .wr_addr(wr_addr), .occ(occ), .push(push), .pop(pop)
);

// File: tb/test_lpc_trig_pipeline.sv
module test_lpc_trig_pipeline;
  localparam int NCH = 128;
  localparam int BD  = 32;
  localparam int AW  = 8;

  function automatic logic [NCH-1:0] pat(input int c);
    logic [NCH-1:0] v;
    v = '0;
    for (int k = 0; k < NCH/32; k++)
      v[k*32 +: 32] = ((32'(c) + 32'd1) * 32'h9E3779B1) ^ (32'(k) * 32'h01010101);
    return v;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0]  latency_i = '0;
  logic [NCH-1:0] hit_i = '0;
  logic trig_i = 1'b0, clr_i = 1'b0, ev_ready_i = 1'b0;
  logic ev_valid_o, ev_lat_err_o, lat_err_o, full_err_o;
  logic [NCH-1:0] ev_hits_o;
  logic [AW-1:0]  ev_addr_o;

  lpc_trig_pipeline i_lpc_trig_pipeline (
    .clk(clk), .rst_n(rst_n), .latency_i(latency_i), .hit_i(hit_i),
    .trig_i(trig_i), .clr_i(clr_i), .ev_valid_o(ev_valid_o),
    .ev_ready_i(ev_ready_i), .ev_hits_o(ev_hits_o), .ev_addr_o(ev_addr_o),
    .ev_lat_err_o(ev_lat_err_o), .lat_err_o(lat_err_o), .full_err_o(full_err_o)
  );

  always #4 clk = ~clk;

  int cyc = 0;                      // index of the next rising edge after reset
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
  always @(negedge clk) hit_i <= pat(cyc);

  int n_chk = 0, n_bad = 0;
  int lat_run, lat_drv, pop_cnt;
  bit err_seen, full_seen;
  int q_cyc [0:4095];
  bit q_err [0:4095];
  int qh, qt;

  task automatic chk(input bit ok, input string req,
                     input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int l);
    @(negedge clk);
    rst_n = 1'b0; trig_i = 0; clr_i = 0; ev_ready_i = 0;
    latency_i = AW'(l); lat_drv = l;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lat_run = l; qh = 0; qt = 0; err_seen = 0; full_seen = 0;
  endtask

  // One clock: check outputs against the model, drive inputs, update the model
  task automatic tick(input bit trig, input bit rdy, input bit clr);
    int occ0, cap; bit mism, tag, drop;
    @(negedge clk);
    chk(ev_valid_o == (qt != qh), "R6 valid", NCH'(ev_valid_o), NCH'(qt != qh));
    chk(lat_err_o == err_seen, "R4 lat_err", NCH'(lat_err_o), NCH'(err_seen));
    chk(full_err_o == full_seen, "R8 full_err", NCH'(full_err_o), NCH'(full_seen));
    trig_i = trig; ev_ready_i = rdy; clr_i = clr; latency_i = AW'(lat_drv);
    occ0 = qt - qh;
    mism = (cyc >= lat_run) && (lat_drv != lat_run);
    tag  = err_seen | mism;
    if (ev_valid_o && rdy && qt != qh) begin
      chk(ev_addr_o == AW'(q_cyc[qh]), "R6 order addr", NCH'(ev_addr_o), NCH'(AW'(q_cyc[qh])));
      chk(ev_hits_o == pat(q_cyc[qh]), "R2 hits", ev_hits_o, pat(q_cyc[qh]));
      chk(ev_lat_err_o == q_err[qh], "R5 tag", NCH'(ev_lat_err_o), NCH'(q_err[qh]));
      qh++; pop_cnt++;
    end
    drop = 0;
    if (trig && cyc >= lat_run) begin
      if (occ0 < BD) begin
        cap = cyc - ((lat_run == 0) ? 256 : lat_run);
        q_cyc[qt] = cap; q_err[qt] = tag; qt++;
      end else drop = 1;
    end
    if (mism) err_seen = 1; else if (clr) err_seen = 0;
    if (drop) full_seen = 1; else if (clr) full_seen = 0;
  endtask

  // latency, trigger clock, expected captured clock (-1: no event)
  localparam int VEC [0:8][0:2] = '{
    '{10, 10, 0}, '{10, 300, 290}, '{200, 255, 55}, '{255, 600, 345},
    '{1, 1, 0}, '{3, 2, -1}, '{50, 49, -1}, '{0, 300, 44}, '{128, 129, 1}
  };

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, p0;
    pop_cnt = 0;
    // R6: reset state
    do_reset(5);
    @(negedge clk);
    chk(!ev_valid_o && !lat_err_o && !full_err_o, "R6 reset", NCH'({ev_valid_o, lat_err_o, full_err_o}), '0);

    // R1 R2 R3: vector table
    for (int v = 0; v < 9; v++) begin
      do_reset(VEC[v][0]);
      while (cyc + 1 < VEC[v][1]) tick(0, 0, 0);
      tick(1, 0, 0);
      tick(0, 0, 0);
      if (VEC[v][2] < 0) begin
        chk(!ev_valid_o, "R3 ignored", NCH'(ev_valid_o), '0);
      end else begin
        chk(ev_valid_o, "R2 valid", NCH'(ev_valid_o), NCH'(1));
        chk(ev_addr_o == AW'(VEC[v][2]), "R1 addr", NCH'(ev_addr_o), NCH'(AW'(VEC[v][2])));
        chk(ev_hits_o == pat(VEC[v][2]), "R2 hits", ev_hits_o, pat(VEC[v][2]));
      end
      tick(0, 1, 0); tick(0, 1, 0);
    end

    // R7 back-pressure, then R9 trigger with pop
    do_reset(6);
    while (cyc + 1 < 10) tick(0, 0, 0);
    tick(1, 0, 0); tick(1, 0, 0);
    for (int i = 0; i < 5; i++) begin
      tick(0, 0, 0);
      chk(ev_valid_o && ev_addr_o == 8'd4, "R7 hold", NCH'(ev_addr_o), NCH'(4));
    end
    tick(1, 1, 0);
    tick(0, 0, 0);
    chk(ev_valid_o && ev_addr_o == 8'd5, "R9 head", NCH'(ev_addr_o), NCH'(5));
    repeat (4) tick(0, 1, 0);

    // R8: fill, drop, clear
    do_reset(4);
    while (cyc + 1 < 10) tick(0, 0, 0);
    repeat (33) tick(1, 0, 0);
    tick(0, 0, 0);
    chk(full_err_o, "R8 drop flag", NCH'(full_err_o), NCH'(1));
    tick(1, 0, 1);
    tick(0, 0, 0);
    chk(full_err_o, "R8 set wins", NCH'(full_err_o), NCH'(1));
    tick(0, 0, 1);
    tick(0, 0, 0);
    chk(!full_err_o, "R8 clear", NCH'(full_err_o), '0);
    p0 = pop_cnt;
    repeat (40) tick(0, 1, 0);
    chk(pop_cnt - p0 == BD, "R8 depth", NCH'(pop_cnt - p0), NCH'(BD));

    // R10: trigger every third clock
    do_reset(20);
    while (cyc + 1 < 25) tick(0, 1, 0);
    p0 = pop_cnt;
    for (int k = 0; k < 60; k++) begin
      tick(1, 1, 0); tick(0, 1, 0); tick(0, 1, 0);
    end
    repeat (4) tick(0, 1, 0);
    chk(pop_cnt - p0 == 60, "R10 rate", NCH'(pop_cnt - p0), NCH'(60));

    // R4 R5: latency change while running
    do_reset(8);
    while (cyc + 1 < 20) tick(0, 0, 0);
    tick(1, 0, 0);
    repeat (3) tick(0, 0, 0);
    lat_drv = 9;
    tick(1, 0, 0);
    tick(0, 0, 0);
    chk(lat_err_o, "R4 raise", NCH'(lat_err_o), NCH'(1));
    tick(0, 0, 1);
    lat_drv = 8;
    tick(0, 0, 1);
    tick(0, 0, 0);
    chk(!lat_err_o, "R4 clear", NCH'(lat_err_o), '0);
    tick(1, 0, 0);
    tick(0, 0, 0);
    a = 0;
    for (int i = 0; i < 3; i++) begin
      if (i == 1) chk(ev_lat_err_o, "R5 tagged", NCH'(ev_lat_err_o), NCH'(1));
      else        chk(!ev_lat_err_o, "R5 untagged", NCH'(ev_lat_err_o), '0);
      tick(0, 1, 0);
      a++;
      tick(0, 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule